// File: doc/BRIEF.md
# Composite Sync Separator

This block splits one composite sync stream, in which horizontal and vertical sync share a single wire, into a horizontal sync output and a vertical sync output. The input may be of either polarity. The block first turns it into a stream whose active level is high. It then recovers vertical sync by pulse width: only a long high run counts as vertical. During the vertical interval the horizontal output keeps running, at first by passing the real line pulses and then by generating its own pulses.

Inside each vertical interval, the block counts the line edges and keeps the final count for the next frame. In the next frame it passes that many edges through unchanged. After that it switches to generated pulses of fixed width. Their period is copied from the spacing of the last two passed edges. All durations are given in microseconds and scaled by a clocks-per-microsecond parameter. The input is taken as synchronous to `clk`.

Top module: `csync_splitter`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after its release, both `hsync_o` and `vsync_o` are 0. Polarity starts as positive, the line count kept from the previous frame starts at 0, and no period is yet measured.
- R2: The input is sampled over back-to-back windows of POL_WIN_US microseconds. If the high cycles in a window exceed half of the window, the input is taken as negative and is inverted for the next window; otherwise it is used as is. Outside vertical sync, `hsync_o` carries the normalized input, so a line pulse keeps its width.
- R3: `vsync_o` rises only after the normalized input has been high for VS_MIN_US·CLK_PER_US consecutive cycles. A high run one cycle shorter never raises it.
- R4: Once high, `vsync_o` falls VS_MIN_US·CLK_PER_US cycles after the normalized input goes low, unless the input rises again before then. Its high time therefore equals the span from the rise of the vertical pulse to the last fall of the group of pulses it bridges.
- R5: Rising edges of the normalized input that occur while vertical sync is high are counted. When vertical sync ends, the count is stored as the line count for the next frame.
- R6: In a vertical interval, `hsync_o` follows the normalized input until the running count reaches the stored line count.
- R7: From then until vertical sync ends, `hsync_o` carries generated pulses INS_US·CLK_PER_US cycles wide. The phase starts one cycle after the last passed edge, so the first generated pulse starts one period after that edge.
- R8: The generated period is the spacing of the last two rising edges that were passed through with no generated stretch between them. Until such a pair exists, it is DEF_LINE_US·CLK_PER_US cycles.
- R9: A change of `csync_i` sampled at clock edge 1 reaches `hsync_o` after edge 3 when passed. A vertical pulse's rise shows on `vsync_o` after edge VS_MIN_US·CLK_PER_US+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_i | input | 1 | Composite sync input, either polarity |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |

## Verification
The passed horizontal path has three register stages from input to `hsync_o`. The vertical output has VS_MIN+2 stages to its rise and exactly VS_MIN cycles of hold after the normalized fall. The latency check counts those falling clock edges and samples on them. All other results are measured as spans between output edges, taken at falling clock edges: the vertical high time, the gap and width of generated pulses, and the number of passed edges. This fixed latency cancels out of those spans, so the expected values come straight from the stimulus timing. The line count needs one settled frame, and the period needs two passed edges, so those checks are made on the third frame after reset.

// File: rtl/csync_pkg.sv
package csync_pkg;
    typedef enum logic {
        HSRC_PASS = 1'b0,
        HSRC_GEN  = 1'b1
    } hsrc_e;
endpackage

// File: rtl/csync_polarity.sv
module csync_polarity #(
    parameter int WIN = 13824
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic pos_o
);
    localparam int WW = $clog2(WIN + 1);

    typedef struct packed {
        logic [WW-1:0] wc;
        logic [WW-1:0] hi;
        logic          smp;
        logic          neg;
        logic          pos;
    } pol_t;

    pol_t s_d, s_q;
    logic [WW-1:0] hi_sum;

    always_comb begin
        s_d     = s_q;
        hi_sum  = s_q.hi + WW'(s_q.smp);
        s_d.smp = raw_i;
        s_d.pos = s_q.smp ^ s_q.neg;
        if (s_q.wc == WW'(WIN - 1)) begin
            s_d.neg = (hi_sum > WW'(WIN / 2));
            s_d.wc  = '0;
            s_d.hi  = '0;
        end else begin
            s_d.wc = s_q.wc + 1'b1;
            s_d.hi = hi_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos_o = s_q.pos;

    logic          neg_w;
    logic [WW-1:0] wc_w;
    assign neg_w = s_q.neg;
    assign wc_w  = s_q.wc;

    // R2: the polarity decision only moves at a window boundary
    a_r2_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_w != WW'(WIN - 1)) |=> $stable(neg_w));
endmodule

// File: rtl/csync_vsep.sv
module csync_vsep #(
    parameter int RUN_MIN = 216,
    parameter int HOLD    = 216
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    output logic vs_o
);
    localparam int RW = $clog2(RUN_MIN + 1);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [RW-1:0] rc;
        logic [HW-1:0] hc;
        logic          vs;
    } vs_t;

    vs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!pos_i)                        s_d.rc = '0;
        else if (s_q.rc != RW'(RUN_MIN))   s_d.rc = s_q.rc + 1'b1;

        if (s_q.vs && !pos_i) s_d.hc = s_q.hc + 1'b1;
        else                  s_d.hc = '0;

        if (!s_q.vs)
            s_d.vs = pos_i && (s_q.rc >= RW'(RUN_MIN - 1));
        else
            s_d.vs = pos_i || (s_q.hc != HW'(HOLD - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vs_o = s_q.vs;

    logic [RW-1:0] rc_w;
    assign rc_w = s_q.rc;

    // R3: vertical only starts after a full-length high run
    a_r3_run_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_o) |-> ($past(pos_i) && ($past(rc_w) >= RW'(RUN_MIN - 1))));
    // R4: vertical only ends while the normalized input is low
    a_r4_fall_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_o) |-> !$past(pos_i));
endmodule

// File: rtl/csync_hgen.sv
module csync_hgen
    import csync_pkg::*;
#(
    parameter int INS_W   = 54,
    parameter int DEF_PER = 864,
    parameter int PER_W   = 12,
    parameter int CNT_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic vs_i,
    output logic hs_o
);
    localparam logic [PER_W-1:0] PMAX = '1;
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic             pos_prev;
        logic             vs_prev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] nh;
        logic [PER_W-1:0] gap;
        logic [PER_W-1:0] per;
        logic             have;
        logic             per_ok;
        hsrc_e            src;
        logic [PER_W-1:0] ph;
        logic [PER_W-1:0] plen;
        logic             hs;
    } hg_t;

    hg_t s_d, s_q;
    logic             rise;
    logic             gen_now;
    logic [PER_W-1:0] ph_use;
    logic [PER_W-1:0] plen_use;

    always_comb begin
        s_d          = s_q;
        rise         = pos_i && !s_q.pos_prev;
        s_d.pos_prev = pos_i;
        s_d.vs_prev  = vs_i;

        if (!vs_i)                    s_d.cnt = '0;
        else if (rise && s_q.cnt != CMAX) s_d.cnt = s_q.cnt + 1'b1;

        if (s_q.vs_prev && !vs_i) s_d.nh = s_q.cnt;

        gen_now = vs_i && (s_q.cnt >= s_q.nh);

        if (rise)                s_d.gap = '0;
        else if (s_q.gap != PMAX) s_d.gap = s_q.gap + 1'b1;

        if (rise) begin
            if (gen_now) begin
                s_d.have = 1'b0;
            end else begin
                s_d.have = 1'b1;
                if (s_q.have) begin
                    s_d.per    = (s_q.gap == PMAX) ? s_q.gap : s_q.gap + 1'b1;
                    s_d.per_ok = 1'b1;
                end
            end
        end

        if (gen_now && s_q.src == HSRC_PASS) begin
            plen_use = s_q.per_ok ? s_q.per : PER_W'(DEF_PER);
            ph_use   = PER_W'(1);
            s_d.plen = plen_use;
        end else begin
            plen_use = s_q.plen;
            ph_use   = s_q.ph;
        end

        if (gen_now) begin
            s_d.src = HSRC_GEN;
            s_d.hs  = (ph_use < PER_W'(INS_W));
            s_d.ph  = (ph_use >= plen_use - 1'b1) ? '0 : ph_use + 1'b1;
        end else begin
            s_d.src = HSRC_PASS;
            s_d.hs  = pos_i;
            s_d.ph  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hs_o = s_q.hs;

    logic             vs_prev_w;
    logic             gen_w;
    logic [CNT_W-1:0] nh_w;
    logic [CNT_W-1:0] cnt_w;
    logic [PER_W-1:0] per_w;
    assign vs_prev_w = s_q.vs_prev;
    assign gen_w     = (s_q.src == HSRC_GEN);
    assign nh_w      = s_q.nh;
    assign cnt_w     = s_q.cnt;
    assign per_w     = s_q.per;

    // R5: the stored line count is the edge count at the end of vertical
    a_r5_count_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_prev_w && !vs_i) |=> (nh_w == $past(cnt_w)));
    // R6: outside generation the output is the input one cycle later
    a_r6_pass_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_w |-> (hs_o == $past(pos_i)));
    // R8: the period only moves on a passed rising edge
    a_r8_period_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_w) |-> $past(rise && !gen_now));
endmodule

// File: rtl/csync_splitter.sv
module csync_splitter #(
    parameter int CLK_PER_US  = 27,
    parameter int VS_MIN_US   = 8,
    parameter int INS_US      = 2,
    parameter int DEF_LINE_US = 32,
    parameter int POL_WIN_US  = 512,
    parameter int MAX_VLINES  = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_i,
    output logic hsync_o,
    output logic vsync_o
);
    localparam int RUN_MIN = VS_MIN_US * CLK_PER_US;
    localparam int INS_W   = INS_US * CLK_PER_US;
    localparam int DEF_PER = DEF_LINE_US * CLK_PER_US;
    localparam int WIN     = POL_WIN_US * CLK_PER_US;
    localparam int PER_W   = $clog2(4 * DEF_PER);
    localparam int CNT_W   = $clog2(MAX_VLINES + 1);

    logic pos_w;
    logic vs_w;

    csync_polarity #(.WIN(WIN)) u_pol (
        .clk  (clk),
        .rst_n(rst_n),
        .raw_i(csync_i),
        .pos_o(pos_w)
    );

    csync_vsep #(.RUN_MIN(RUN_MIN), .HOLD(RUN_MIN)) u_vsep (
        .clk  (clk),
        .rst_n(rst_n),
        .pos_i(pos_w),
        .vs_o (vs_w)
    );

    csync_hgen #(
        .INS_W  (INS_W),
        .DEF_PER(DEF_PER),
        .PER_W  (PER_W),
        .CNT_W  (CNT_W)
    ) u_hgen (
        .clk  (clk),
        .rst_n(rst_n),
        .pos_i(pos_w),
        .vs_i (vs_w),
        .hs_o (hsync_o)
    );

    assign vsync_o = vs_w;
endmodule

// File: tb/csync_splitter_test.sv
module csync_splitter_test;
    localparam int CPU   = 4;
    localparam int RUN   = 8 * CPU;
    localparam int INSW  = 2 * CPU;
    localparam int DEFP  = 32 * CPU;
    localparam int WINC  = 512 * CPU;
    localparam int HWID  = 16;
    localparam int NOTCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_i = 1'b0;
    logic hsync_o, vsync_o;

    always #2.5 clk = ~clk;

    csync_splitter #(
        .CLK_PER_US(CPU), .VS_MIN_US(8), .INS_US(2),
        .DEF_LINE_US(32), .POL_WIN_US(512), .MAX_VLINES(63)
    ) uut (
        .clk(clk), .rst_n(rst_n), .csync_i(csync_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o)
    );

    int total = 0;
    int bad = 0;
    bit inv = 0;
    int line_len = 120;
    int vlines = 4;

    // edge monitor, sampled at falling clock edges
    int tcyc = 0;
    bit hs_prev = 0, vs_prev = 0;
    int vs_t0 = 0, nr = 0, r1 = 0, r2 = 0, w1 = -1;
    int frames = 0, l_dur = 0, l_nr = 0, l_gap = 0, l_w1 = 0;
    int ho_t = 0, ho_w = -1;

    always @(negedge clk) begin
        tcyc++;
        if (!rst_n) begin
            hs_prev = 0; vs_prev = 0; ho_w = -1;
        end else begin
            if (vsync_o && !vs_prev) begin
                vs_t0 = tcyc; nr = 0; r1 = 0; r2 = 0; w1 = -1;
            end
            if (vsync_o && hsync_o && !hs_prev) begin
                nr++;
                if (nr == 1) r1 = tcyc;
                else if (nr == 2) r2 = tcyc;
            end
            if (vsync_o && !hsync_o && hs_prev && nr == 1 && w1 < 0) w1 = tcyc - r1;
            if (!vsync_o && vs_prev) begin
                frames++; l_dur = tcyc - vs_t0; l_nr = nr; l_gap = r2 - r1; l_w1 = w1;
            end
            if (!vsync_o && hsync_o && !hs_prev) ho_t = tcyc;
            if (!vsync_o && !hsync_o && hs_prev) ho_w = tcyc - ho_t;
            hs_prev = hsync_o; vs_prev = vsync_o;
        end
    end

    function automatic int exp_vs_len(int vl, int ln);
        return vl * ln + HWID;
    endfunction

    function automatic int exp_gen_gap(bit measured, int ln);
        return measured ? ln : DEFP;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic drive(input bit lvl, input int n);
        csync_i = lvl ^ inv;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit inv_in);
        inv = inv_in;
        csync_i = inv;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", hsync_o, 0, "hsync in reset");
        chk("R1", vsync_o, 0, "vsync in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", hsync_o, 0, "hsync after release");
        chk("R1", vsync_o, 0, "vsync after release");
    endtask

    task automatic lines(input int n);
        repeat (n) begin
            drive(1, HWID);
            drive(0, line_len - HWID);
        end
    endtask

    task automatic vframe();
        repeat (vlines) begin
            drive(1, line_len - NOTCH);
            drive(0, NOTCH);
        end
        lines(20);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));

        // R9 latency, positive input
        do_reset(0);
        drive(0, 50);
        csync_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", hsync_o, 0, "hsync before third edge");
        @(negedge clk);
        chk("R9", hsync_o, 1, "hsync after third edge");
        repeat (30) @(negedge clk);
        chk("R9", vsync_o, 0, "vsync before edge RUN+2");
        @(negedge clk);
        chk("R9", vsync_o, 1, "vsync after edge RUN+2");
        drive(0, 200);

        // R3 boundary: one cycle short, then exact
        begin
            int f0;
            f0 = frames;
            drive(1, RUN - 1);
            drive(0, 200);
            chk("R3", frames - f0, 0, "short run raised vsync");
            drive(1, RUN);
            drive(0, 200);
            chk("R3", frames - f0, 1, "exact run vsync count");
            chk("R4", l_dur, RUN, "vsync high time for exact run");
        end

        // R8 default period with no measured lines, R7 width
        do_reset(0);
        drive(0, 200);
        drive(1, 600);
        drive(0, 200);
        chk("R8", l_gap, exp_gen_gap(0, 0), "default generated period");
        chk("R7", l_w1, INSW, "generated pulse width");
        chk("R4", l_dur, 600, "vsync high time single pulse");

        for (int it = 0; it < 5; it++) begin
            bit pol;
            if (it == 0) begin
                line_len = 120; vlines = 4; pol = 0;
            end else begin
                line_len = $urandom_range(100, 160);
                vlines   = $urandom_range(3, 4);
                pol      = $urandom_range(0, 1);
            end
            do_reset(pol);
            lines((2 * WINC) / line_len + 3);
            chk("R2", ho_w, HWID, "normalized line pulse width");

            vframe();
            if (!pol) begin
                chk("R8", l_gap, exp_gen_gap(1, line_len), "measured generated period");
                chk("R7", l_w1, INSW, "generated width first frame");
            end
            vframe();
            vframe();
            chk("R5", l_nr, vlines, "passed edges equal stored count");
            chk("R6", l_w1, line_len - NOTCH, "passed pulse keeps input width");
            chk("R4", l_dur, exp_vs_len(vlines, line_len), "vsync high time");
            chk("R6", l_gap, line_len, "passed edge spacing");
        end

        summary();
    end
endmodule